// File: doc/BRIEF.md
# Pixel Block Border Locator

This block follows the raster position of a sampled video stream and, for every accepted sample, tells downstream noise-reduction logic whether that sample sits in the transition zone at the edge of a square compression block or inside the block. A pixel is carried by two consecutive valid samples, so the horizontal position advances once for every pair. A line-start marker returns the horizontal position to zero and steps the row; a frame-start marker returns both to zero.

The grid is programmable: blocks are 8x8 or 16x16 pixels, the border zone is 2 or 4 pixels wide and is split evenly across each block boundary, and a 4-bit phase shift moves the horizontal grid by 0 to 15 pixels so that a fixed border position can be matched to video whose horizontal timing has drifted. All three settings are captured together at a frame start and held for the whole frame, so the grid never jumps in mid-picture. The flag is produced one clock after the sample it describes, qualified by its own valid bit.

Top module: `blk_border_locator`

## Requirements
- R1: While reset is high and on the first cycle after it, `flag_vld` and `border` are 0.
- R2: `flag_vld` is 1 exactly on the cycle after a cycle with `smp_vld` high; `border` is 0 whenever `flag_vld` is 0.
- R3: The horizontal pixel index advances by one after every two valid samples; both samples of a pixel get the same flag, and cycles with `smp_vld` low move no counter.
- R4: `cfg_blk16` = 0 selects an 8-pixel block pitch, 1 selects a 16-pixel pitch, on both axes.
- R5: With pitch N and `cfg_bdr4` = 0 a coordinate is border when its position in the block p equals 0 or N-1; with `cfg_bdr4` = 1 when p is 0, 1, N-2 or N-1.
- R6: The horizontal position in the block is (pixel index + `cfg_shift`) mod N; the vertical position is (row index) mod N with no shift.
- R7: A valid sample with `line_start` high (and `frame_start` low) is pixel 0, first sample, and belongs to the row after the previous one.
- R8: A valid sample with `frame_start` high is pixel 0 of row 0 and loads `cfg_blk16`, `cfg_bdr4` and `cfg_shift`; these apply from that sample on, and changes to them at any other time have no effect until the next such sample.
- R9: `border` is 1 when the horizontal or the vertical coordinate is in a border zone.
- R10: `line_start` and `frame_start` on a cycle with `smp_vld` low are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample valid strobe |
| line_start | input | 1 | Marks the first sample of a line |
| frame_start | input | 1 | Marks the first sample of a frame |
| cfg_blk16 | input | 1 | Block pitch select: 0 = 8, 1 = 16 pixels |
| cfg_bdr4 | input | 1 | Border width select: 0 = 2, 1 = 4 pixels |
| cfg_shift | input | 4 | Horizontal grid shift, 0 to 15 pixels |
| flag_vld | output | 1 | Flag valid, one cycle after the sample |
| border | output | 1 | Sample lies in a block border zone |

## Verification
The bench aims at the wrap of the shifted horizontal coordinate, where a design that adds the shift without the block-size mask marks the wrong columns in 8-pixel mode, and at the last pixel of a block, where an off-by-one border test would either miss it or widen the zone. It changes the settings in mid-frame to catch a design that applies them at once instead of at the frame start, and holds markers with the valid strobe low to catch counters that reset on unqualified markers. Gapped valid strobes expose a pair counter that advances on idle cycles and splits a pixel's two samples across different flags.

// File: rtl/bbl_pkg.sv
package bbl_pkg;

    localparam int SHIFT_W   = 4;
    localparam int BLK_LOG_S = 3;
    localparam int BLK_LOG_L = 4;
    localparam int GRID_W    = BLK_LOG_L;

    typedef struct packed {
        logic               blk16;
        logic               bdr4;
        logic [SHIFT_W-1:0] shift;
    } grid_cfg_t;

    typedef enum logic [0:0] {
        AXIS_H = 1'b0,
        AXIS_V = 1'b1
    } axis_e;

    // Position inside the block for a coordinate, given the pitch select.
    function automatic logic [GRID_W-1:0] block_pos(input logic [GRID_W-1:0] c,
                                                    input logic blk16);
        logic [GRID_W-1:0] msk;
        msk = blk16 ? GRID_W'((1 << BLK_LOG_L) - 1) : GRID_W'((1 << BLK_LOG_S) - 1);
        return c & msk;
    endfunction

    function automatic logic [GRID_W-1:0] last_pos(input logic blk16);
        return blk16 ? GRID_W'((1 << BLK_LOG_L) - 1) : GRID_W'((1 << BLK_LOG_S) - 1);
    endfunction

    function automatic logic [GRID_W-1:0] half_width(input logic bdr4);
        return bdr4 ? GRID_W'(2) : GRID_W'(1);
    endfunction

endpackage

// File: rtl/bbl_cfg_shadow.sv
module bbl_cfg_shadow
    import bbl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  grid_cfg_t cfg_in,
    output grid_cfg_t cfg_act
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_act <= '0;
        end else if (load) begin
            cfg_act <= cfg_in;
        end
    end

    // R8: settings move only on a frame-start load
    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cfg_act));

    assert_cfg_load_R8: assert property (@(posedge clk) disable iff (rst)
        load |=> cfg_act == $past(cfg_in));

endmodule

// File: rtl/bbl_raster_cnt.sv
module bbl_raster_cnt #(
    parameter int H_W = 10,
    parameter int V_W = 9,
    parameter int SPP = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           adv,
    input  logic           ls,
    input  logic           fs,
    output logic [H_W-1:0] hpos,
    output logic [V_W-1:0] vpos
);

    localparam int PH_W = (SPP > 1) ? $clog2(SPP) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SPP - 1);

    logic [PH_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            hpos  <= '0;
            vpos  <= '0;
            phase <= '0;
        end else if (adv) begin
            if (fs) begin
                hpos  <= '0;
                vpos  <= '0;
                phase <= '0;
            end else if (ls) begin
                hpos  <= '0;
                vpos  <= vpos + V_W'(1);
                phase <= '0;
            end else if (phase == PH_LAST) begin
                phase <= '0;
                hpos  <= hpos + H_W'(1);
            end else begin
                phase <= phase + PH_W'(1);
            end
        end
    end

    // R3: idle cycles leave the raster position alone
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !adv |=> ($stable(hpos) && $stable(vpos) && $stable(phase)));

    // R3: a mid-pixel sample keeps the pixel index
    assert_pair_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (adv && !ls && !fs && phase != PH_LAST) |=> $stable(hpos));

    // R7: line start puts the sample at pixel 0 of the next row
    assert_line_reset_R7: assert property (@(posedge clk) disable iff (rst)
        (adv && ls && !fs) |=> (hpos == '0 && phase == '0 && vpos == $past(vpos) + V_W'(1)));

    // R8: frame start returns to the origin
    assert_frame_origin_R8: assert property (@(posedge clk) disable iff (rst)
        (adv && fs) |=> (hpos == '0 && vpos == '0 && phase == '0));

endmodule

// File: rtl/bbl_zone_test.sv
module bbl_zone_test
    import bbl_pkg::*;
(
    input  logic [GRID_W-1:0] coord,
    input  logic              blk16,
    input  logic              bdr4,
    output logic              hit
);

    logic [GRID_W-1:0] pos;
    logic [GRID_W-1:0] top;
    logic [GRID_W-1:0] half;

    always_comb begin
        pos  = block_pos(coord, blk16);
        top  = last_pos(blk16);
        half = half_width(bdr4);
        hit  = (pos < half) || (pos > (top - half));
    end

    // R5: the first and last position of every block are always border
    always_comb begin
        if (pos == '0 || pos == top) begin
            assert_edge_flag_R5: assert (hit);
        end
    end

endmodule

// File: rtl/blk_border_locator.sv
module blk_border_locator
    import bbl_pkg::*;
#(
    parameter int LINE_PIX    = 720,
    parameter int FRAME_LINES = 485,
    parameter int SPP         = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               smp_vld,
    input  logic               line_start,
    input  logic               frame_start,
    input  logic               cfg_blk16,
    input  logic               cfg_bdr4,
    input  logic [SHIFT_W-1:0] cfg_shift,
    output logic               flag_vld,
    output logic               border
);

    localparam int H_W = $clog2(LINE_PIX);
    localparam int V_W = $clog2(FRAME_LINES);

    grid_cfg_t          cfg_req;
    grid_cfg_t          cfg_act;
    logic [H_W-1:0]     hpos;
    logic [V_W-1:0]     vpos;
    logic [GRID_W-1:0]  coord [2];
    logic [1:0]         axis_hit;
    logic               load;

    assign load    = smp_vld & frame_start;
    assign cfg_req = '{blk16: cfg_blk16, bdr4: cfg_bdr4, shift: cfg_shift};

    bbl_cfg_shadow u_shadow (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .cfg_in  (cfg_req),
        .cfg_act (cfg_act)
    );

    bbl_raster_cnt #(.H_W(H_W), .V_W(V_W), .SPP(SPP)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .adv  (smp_vld),
        .ls   (line_start),
        .fs   (frame_start),
        .hpos (hpos),
        .vpos (vpos)
    );

    assign coord[AXIS_H] = hpos[GRID_W-1:0] + cfg_act.shift;
    assign coord[AXIS_V] = vpos[GRID_W-1:0];

    for (genvar a = 0; a < 2; a++) begin : g_axis
        bbl_zone_test u_zone (
            .coord (coord[a]),
            .blk16 (cfg_act.blk16),
            .bdr4  (cfg_act.bdr4),
            .hit   (axis_hit[a])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_vld <= 1'b0;
        end else begin
            flag_vld <= smp_vld;
        end
    end

    assign border = flag_vld & (|axis_hit);

    assert_vld_follow_R2: assert property (@(posedge clk) disable iff (rst)
        smp_vld |=> flag_vld);

    assert_vld_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> !flag_vld);

    assert_quiet_flag_R2: assert property (@(posedge clk) disable iff (rst)
        !flag_vld |-> !border);

    // R9: a vertical border row flags every valid sample of it
    assert_row_border_R9: assert property (@(posedge clk) disable iff (rst)
        (flag_vld && axis_hit[AXIS_V]) |-> border);

endmodule

// File: tb/sim_blk_border_locator.sv
module sim_blk_border_locator;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       smp_vld, line_start, frame_start;
    logic       cfg_blk16, cfg_bdr4;
    logic [3:0] cfg_shift;
    logic       flag_vld, border;

    int n_checks = 0;
    int n_errors = 0;

    // bench model of the raster
    int  m_h, m_v, m_ph;
    bit  m_b16, m_b4;
    int  m_sh;

    always #(CLK_PERIOD/2) clk = ~clk;

    blk_border_locator u0 (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .line_start(line_start),
        .frame_start(frame_start), .cfg_blk16(cfg_blk16), .cfg_bdr4(cfg_bdr4),
        .cfg_shift(cfg_shift), .flag_vld(flag_vld), .border(border)
    );

    function automatic bit zone(input int c, input bit b16, input bit b4);
        int n, half, p;
        n    = b16 ? 16 : 8;
        half = b4 ? 2 : 1;
        p    = c % n;
        return (p < half) || (p >= n - half);
    endfunction

    function automatic bit expect_flag();
        return zone(m_h + m_sh, m_b16, m_b4) || zone(m_v, m_b16, m_b4);
    endfunction

    task automatic check(input string req, input bit act, input bit exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0b expected=%0b (h=%0d v=%0d)", req, act, exp, m_h, m_v);
        end
    endtask

    // one clock: drive at negedge, sample after the following posedge
    task automatic step(input bit v, input bit ls, input bit fs, input string tag);
        bit e;
        @(negedge clk);
        smp_vld = v; line_start = ls; frame_start = fs;
        if (v) begin
            if (fs) begin
                m_h = 0; m_v = 0; m_ph = 0;
                m_b16 = cfg_blk16; m_b4 = cfg_bdr4; m_sh = int'(cfg_shift);
            end else if (ls) begin
                m_h = 0; m_v++; m_ph = 0;
            end else begin
                m_ph++;
                if (m_ph == 2) begin m_ph = 0; m_h++; end
            end
        end
        e = expect_flag();
        @(posedge clk);
        #1;
        check("R2", flag_vld, v);
        if (v) check(tag, border, e);
        else   check("R2", border, 1'b0);
    endtask

    task automatic set_cfg(input bit b16, input bit b4, input int sh);
        cfg_blk16 = b16; cfg_bdr4 = b4; cfg_shift = 4'(sh);
    endtask

    // one line of npix pixels, vld_pct percent valid cycles
    task automatic run_line(input int npix, input bit first_of_frame,
                            input int vld_pct, input string tag);
        int sent = 0;
        while (sent < 2*npix) begin
            if (sent > 0 && int'($urandom_range(99)) >= vld_pct) begin
                step(0, $urandom_range(1), 0, "R10");
            end else begin
                step(1, sent == 0, first_of_frame && sent == 0, tag);
                sent++;
            end
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        smp_vld = 0; line_start = 0; frame_start = 0;
        set_cfg(0, 0, 0);
        m_h = 0; m_v = 0; m_ph = 0; m_b16 = 0; m_b4 = 0; m_sh = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        #1;
        check("R1", flag_vld, 1'b0);
        check("R1", border, 1'b0);
        @(negedge clk);
        rst = 0;
        @(posedge clk); #1;
        check("R1", flag_vld, 1'b0);

        // 8-pixel pitch, 2-pixel border, no shift, dense
        set_cfg(0, 0, 0);
        for (int l = 0; l < 10; l++) run_line(20, l == 0, 100, "R4 R5 R7 R9");

        // 16-pixel pitch, 4-pixel border, shift wrapping the block
        set_cfg(1, 1, 13);
        for (int l = 0; l < 18; l++) run_line(36, l == 0, 100, "R4 R5 R6 R9");

        // shift larger than the 8 pitch: mask must apply after the add
        set_cfg(0, 1, 11);
        for (int l = 0; l < 4; l++) run_line(24, l == 0, 100, "R6");

        // mid-frame setting change must be held off until frame start
        set_cfg(0, 0, 3);
        run_line(20, 1, 100, "R8");
        set_cfg(1, 1, 9);
        for (int l = 0; l < 3; l++) run_line(20, 0, 100, "R8");
        run_line(20, 1, 100, "R8");

        // markers without valid, gapped valid
        for (int l = 0; l < 4; l++) run_line(30, l == 0, 50, "R3 R10");
        step(0, 1, 1, "R10");
        step(0, 0, 1, "R10");
        step(1, 0, 0, "R10");

        // random frames
        for (int f = 0; f < 12; f++) begin
            set_cfg($urandom_range(1), $urandom_range(1), $urandom_range(15));
            for (int l = 0; l < int'($urandom_range(6, 2)); l++) begin
                run_line($urandom_range(40, 10), l == 0, 75, "R3 R4 R5 R6 R9");
                if ($urandom_range(3) == 0)
                    set_cfg($urandom_range(1), $urandom_range(1), $urandom_range(15));
            end
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule